// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces the per-line timing for an interline CCD area sensor from a single pixel-rate clock. A free-running slot counter sets the line length, issues a one-clock line sync, and marks where the vertical-transfer phase steps fall. It drives the pair of complementary horizontal shift clocks and the per-pixel reset gate pulse. It also labels every output sample with a region code.

The start of each line is a reserved vertical-transfer window. Throughout that window the horizontal clocks and the reset gate stay at their idle levels, so the vertical shift can proceed undisturbed. Once the window closes, the sample stream runs in a fixed order: pre-scan dummy samples first, then a short group of leading optical-black samples, then the active pixels, then a trailing optical-black group. Blanking fills the rest of the line. All outputs are registered. A slot index t = (n-1) mod 2280 is used below, where n counts rising clock edges since reset was released. The outputs seen after edge n describe slot t.

Top module: `ccd_line_timer`

## Requirements
- R1: With default parameters a line is 2280 clocks long, and `lineSync` pulses exactly once every 2280 clocks.
- R2: `lineSync` is high only in slot 2279, for a single clock.
- R3: In slots 0 to 331 (the vertical-transfer window), `hClk1`=0, `hClk2`=1 and `resetGate`=0.
- R4: From slot 332 to slot 2279, `hClk1` toggles on every clock, starting at 1 in slot 332. Its value in slot t is therefore 1 exactly when t-332 is even.
- R5: `hClk2` is the exact complement of `hClk1` in every cycle after reset.
- R6: `resetGate` is high for one clock at each rise of `hClk1`, that is, exactly when `hClk1`=1 outside the window. It is never high inside the window.
- R7: `region` is 3 bits wide, with 0 = blanking, 1 = pre-scan dummy, 2 = leading optical black, 3 = active, 4 = trailing optical black. No other value ever appears.
- R8: The region order is: slots 332–359 dummy (28), 360–361 leading black (2), 362–2011 active (1650), 2012–2063 trailing black (52), and slots 2064–2279 and 0–331 blanking.
- R9: While synchronous reset `rst` is high, the outputs are `lineSync`=0, `hClk1`=0, `hClk2`=1, `resetGate`=0, `vStep`=0 and `region`=0. After release the line restarts at slot 0.
- R10: `vStep` pulses for one clock in slots 52, 92, 132, 172, 212, 252, 292 and 332, which are eight steps 40 clocks apart, and in no other slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock (nominally about 17.9 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| lineSync | output | 1 | One-clock pulse in the last slot of each line |
| vStep | output | 1 | One-clock pulse at each vertical-transfer phase step |
| hClk1 | output | 1 | Horizontal shift clock, first phase |
| hClk2 | output | 1 | Horizontal shift clock, complementary phase |
| resetGate | output | 1 | Per-pixel output reset pulse |
| region | output | 3 | Region code of the current sample |

## Verification
Some properties are checked on every cycle: the counter stays below the line length and wraps to zero, the two shift clocks stay complementary, the reset gate appears only on a rising shift clock, and line sync and step pulses last a single clock with line sync always falling in blanking. Other behaviour can only be shown by the bench's scenarios. These are the exact slot positions of each region boundary, the phase of the shift clock at the end of the window, the step positions, the 2280-clock sync period, and the restart at slot 0 after a reset applied mid-line. The bench checks these against its own slot model and against a table of boundary slots.

// File: rtl/ccd_line_pkg.sv
package ccd_line_pkg;

  // Region labels carried with each output sample
  typedef enum logic [2:0] {
    RG_BLANK    = 3'd0,
    RG_DUMMY    = 3'd1,
    RG_OB_LEAD  = 3'd2,
    RG_ACTIVE   = 3'd3,
    RG_OB_TRAIL = 3'd4
  } region_e;

  // Strobes decoded from the slot counter, consumed by the output stage
  typedef struct packed {
    logic    lineEnd;
    logic    shiftEn;
    logic    vStep;
    region_e region;
  } line_strobe_t;

endpackage

// File: rtl/ccd_line_ctrl.sv
module ccd_line_ctrl
  import ccd_line_pkg::*;
#(
  parameter int LINE_LEN  = 2280,
  parameter int VT_FIRST  = 52,
  parameter int VT_STEP   = 40,
  parameter int VT_EDGES  = 8,
  parameter int N_DUMMY   = 28,
  parameter int N_OB_LEAD = 2,
  parameter int N_ACTIVE  = 1650,
  parameter int N_OB_TRL  = 52
) (
  input  logic         clk,
  input  logic         rst,
  output line_strobe_t strobe
);

  localparam int CW        = $clog2(LINE_LEN);
  localparam int VT_END    = VT_FIRST + VT_STEP * (VT_EDGES - 1);
  localparam int DUMMY_END = VT_END + N_DUMMY;
  localparam int LEAD_END  = DUMMY_END + N_OB_LEAD;
  localparam int ACT_END   = LEAD_END + N_ACTIVE;
  localparam int TRL_END   = ACT_END + N_OB_TRL;

  localparam logic [CW-1:0] LAST_C  = CW'(LINE_LEN - 1);
  localparam logic [CW-1:0] VT_C    = CW'(VT_END);
  localparam logic [CW-1:0] DUMMY_C = CW'(DUMMY_END);
  localparam logic [CW-1:0] LEAD_C  = CW'(LEAD_END);
  localparam logic [CW-1:0] ACT_C   = CW'(ACT_END);
  localparam logic [CW-1:0] TRL_C   = CW'(TRL_END);

  logic [CW-1:0]       slotCnt;
  logic [VT_EDGES-1:0] stepHit;
  region_e             regionNow;

  // Free-running slot counter
  always_ff @(posedge clk) begin
    if (rst)                  slotCnt <= '0;
    else if (slotCnt == LAST_C) slotCnt <= '0;
    else                      slotCnt <= slotCnt + CW'(1);
  end

  // One comparator per vertical-transfer step position
  for (genvar i = 0; i < VT_EDGES; i++) begin : g_step
    assign stepHit[i] = (slotCnt == CW'(VT_FIRST + i * VT_STEP));
  end

  always_comb begin
    if (slotCnt < VT_C)           regionNow = RG_BLANK;
    else if (slotCnt < DUMMY_C)   regionNow = RG_DUMMY;
    else if (slotCnt < LEAD_C)    regionNow = RG_OB_LEAD;
    else if (slotCnt < ACT_C)     regionNow = RG_ACTIVE;
    else if (slotCnt < TRL_C)     regionNow = RG_OB_TRAIL;
    else                          regionNow = RG_BLANK;
  end

  always_comb begin
    strobe.lineEnd = (slotCnt == LAST_C);
    strobe.shiftEn = (slotCnt >= VT_C);
    strobe.vStep   = |stepHit;
    strobe.region  = regionNow;
  end

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    slotCnt <= LAST_C);

  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (slotCnt == LAST_C) |=> (slotCnt == '0));

endmodule

// File: rtl/ccd_line_out.sv
module ccd_line_out
  import ccd_line_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  line_strobe_t strobe,
  output logic         lineSync,
  output logic         vStep,
  output logic         hClk1,
  output logic         hClk2,
  output logic         resetGate,
  output region_e      regionQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lineSync  <= 1'b0;
      vStep     <= 1'b0;
      hClk1     <= 1'b0;
      hClk2     <= 1'b1;
      resetGate <= 1'b0;
      regionQ   <= RG_BLANK;
    end else begin
      lineSync  <= strobe.lineEnd;
      vStep     <= strobe.vStep;
      hClk1     <= strobe.shiftEn ? ~hClk1 : 1'b0;
      hClk2     <= strobe.shiftEn ? hClk1 : 1'b1;
      resetGate <= strobe.shiftEn & ~hClk1;
      regionQ   <= strobe.region;
    end
  end

  // R5
  hclk_compl_chk: assert property (@(posedge clk) disable iff (rst)
    hClk2 == ~hClk1);

  // R6
  rg_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    resetGate |-> $rose(hClk1));

  // R2
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    lineSync |=> !lineSync);

  // R2
  sync_blank_chk: assert property (@(posedge clk) disable iff (rst)
    lineSync |-> (regionQ == RG_BLANK));

  // R10
  step_single_chk: assert property (@(posedge clk) disable iff (rst)
    vStep |=> !vStep);

  // R7
  region_legal_chk: assert property (@(posedge clk) disable iff (rst)
    regionQ <= RG_OB_TRAIL);

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_line_pkg::*;
#(
  parameter int LINE_LEN  = 2280,
  parameter int VT_FIRST  = 52,
  parameter int VT_STEP   = 40,
  parameter int VT_EDGES  = 8,
  parameter int N_DUMMY   = 28,
  parameter int N_OB_LEAD = 2,
  parameter int N_ACTIVE  = 1650,
  parameter int N_OB_TRL  = 52
) (
  input  logic       clk,
  input  logic       rst,
  output logic       lineSync,
  output logic       vStep,
  output logic       hClk1,
  output logic       hClk2,
  output logic       resetGate,
  output logic [2:0] region
);

  line_strobe_t strobe;
  region_e      regionQ;

  ccd_line_ctrl #(
    .LINE_LEN (LINE_LEN),
    .VT_FIRST (VT_FIRST),
    .VT_STEP  (VT_STEP),
    .VT_EDGES (VT_EDGES),
    .N_DUMMY  (N_DUMMY),
    .N_OB_LEAD(N_OB_LEAD),
    .N_ACTIVE (N_ACTIVE),
    .N_OB_TRL (N_OB_TRL)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe)
  );

  ccd_line_out out_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .lineSync (lineSync),
    .vStep    (vStep),
    .hClk1    (hClk1),
    .hClk2    (hClk2),
    .resetGate(resetGate),
    .regionQ  (regionQ)
  );

  assign region = regionQ;

endmodule

// File: tb/ccd_line_timer_tb_top.sv
module ccd_line_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LINE = 2280;
  localparam int NV = 16;
  // slot, region, hClk1, resetGate, lineSync, vStep
  localparam int VEC [0:NV-1][0:5] = '{
    '{0,    0, 0, 0, 0, 0},
    '{52,   0, 0, 0, 0, 1},
    '{53,   0, 0, 0, 0, 0},
    '{92,   0, 0, 0, 0, 1},
    '{331,  0, 0, 0, 0, 0},
    '{332,  1, 1, 1, 0, 1},
    '{333,  1, 0, 0, 0, 0},
    '{359,  1, 0, 0, 0, 0},
    '{360,  2, 1, 1, 0, 0},
    '{361,  2, 0, 0, 0, 0},
    '{362,  3, 1, 1, 0, 0},
    '{2011, 3, 0, 0, 0, 0},
    '{2012, 4, 1, 1, 0, 0},
    '{2063, 4, 0, 0, 0, 0},
    '{2064, 0, 1, 1, 0, 0},
    '{2279, 0, 0, 0, 1, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineSync, vStep, hClk1, hClk2, resetGate;
  logic [2:0] region;

  int errors = 0;
  int checks = 0;
  int n = 0;
  int slot = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_line_timer dut_i (
    .clk(clk), .rst(rst), .lineSync(lineSync), .vStep(vStep),
    .hClk1(hClk1), .hClk2(hClk2), .resetGate(resetGate), .region(region)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s slot=%0d actual=%0d expected=%0d", req, what, slot, act, exp);
    end
  endtask

  task automatic stepClk();
    @(posedge clk);
    n++;
    slot = (n - 1) % LINE;
    @(negedge clk);
  endtask

  function automatic int expRegion(input int t);
    if (t < 332)  return 0;
    if (t < 360)  return 1;
    if (t < 362)  return 2;
    if (t < 2012) return 3;
    if (t < 2064) return 4;
    return 0;
  endfunction

  function automatic int expH1(input int t);
    return (t >= 332 && ((t - 332) % 2 == 0)) ? 1 : 0;
  endfunction

  function automatic int expStep(input int t);
    return (t >= 52 && t <= 332 && ((t - 52) % 40 == 0)) ? 1 : 0;
  endfunction

  task automatic checkModel();
    chk(t2s("R8"), "region", int'(region), expRegion(slot));
    chk(t2s(slot < 332 ? "R3" : "R4"), "hClk1", int'(hClk1), expH1(slot));
    chk(t2s("R5"), "hClk2", int'(hClk2), 1 - expH1(slot));
    chk(t2s("R6"), "resetGate", int'(resetGate), expH1(slot));
    chk(t2s("R2"), "lineSync", int'(lineSync), (slot == LINE - 1) ? 1 : 0);
    chk(t2s("R10"), "vStep", int'(vStep), expStep(slot));
  endtask

  function automatic string t2s(input string s);
    return s;
  endfunction

  task automatic checkIdle(input string tag);
    chk(tag, "lineSync idle", int'(lineSync), 0);
    chk(tag, "vStep idle", int'(vStep), 0);
    chk(tag, "hClk1 idle", int'(hClk1), 0);
    chk(tag, "hClk2 idle", int'(hClk2), 1);
    chk(tag, "resetGate idle", int'(resetGate), 0);
    chk(tag, "region idle", int'(region), 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int lastSync;
    int syncSeen;
    repeat (3) @(negedge clk);
    // R9: reset state
    checkIdle("R9");
    rst = 1'b0;

    // First full line against the slot model (R2 R3 R4 R5 R6 R8 R10)
    for (int i = 0; i < LINE; i++) begin
      stepClk();
      checkModel();
      // R7: only legal codes
      if (region > 3'd4) chk("R7", "region legal", int'(region), 4);
    end

    // Table walk over the boundary slots of the second line
    for (int v = 0; v < NV; v++) begin
      do stepClk(); while (slot != VEC[v][0]);
      chk("R8", "table region", int'(region), VEC[v][1]);
      chk("R7", "table region width", int'(region) & ~7, 0);
      chk("R4", "table hClk1", int'(hClk1), VEC[v][2]);
      chk("R6", "table resetGate", int'(resetGate), VEC[v][3]);
      chk("R2", "table lineSync", int'(lineSync), VEC[v][4]);
      chk("R10", "table vStep", int'(vStep), VEC[v][5]);
    end

    // R1: line sync period over the next lines
    lastSync = n;
    syncSeen = 0;
    for (int i = 0; i < 2 * LINE; i++) begin
      stepClk();
      if (lineSync) begin
        syncSeen++;
        chk("R1", "sync period", n - lastSync, LINE);
        lastSync = n;
      end
    end
    chk("R1", "sync count", syncSeen, 2);

    // R9: reset applied mid-line, inside the shifting area
    do stepClk(); while (slot != 1000);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkIdle("R9");
    @(posedge clk);
    @(negedge clk);
    checkIdle("R9");
    rst = 1'b0;
    n = 0;
    stepClk();
    chk("R9", "restart region", int'(region), 0);
    chk("R9", "restart hClk1", int'(hClk1), 0);
    do stepClk(); while (slot != 52);
    chk("R9", "restart step at 52", int'(vStep), 1);
    do stepClk(); while (slot != 332);
    chk("R9", "restart hClk1 at 332", int'(hClk1), 1);
    chk("R9", "restart region at 332", int'(region), 1);
    do stepClk(); while (slot != 2279);
    chk("R9", "restart lineSync", int'(lineSync), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule